// File: doc/BRIEF.md
# Three-slot token synchronizing queue

This block couples two pipelines that share one clock. Each time an instruction leaves a producer stage, that stage drops a small token into the queue. The token can carry a payload such as an accept-or-bounce bit, a transfer length or a cancel bit. The partner stage in the other pipeline watches the queue's empty flag. Its instruction may advance only while a token is waiting, and in that same cycle it pops the token and uses the payload shown at the head.

The queue holds at most three tokens. The geometry of the two pipelines guarantees the producer never has more than three tokens outstanding. For that reason the push side has a valid strobe and no ready: there is no back-pressure, and the producer is never stalled by the queue. The pop side is a plain request that is qualified by the empty flag.

A synchronous flush discards every held token. It is used when both pipelines are cleared together.

Top module: `tok_sync_queue`

## Requirements
- R1: After reset, `empty` is 1.
- R2: A push is not bypassed to the head. In the cycle of a push into an empty queue, `empty` stays 1. On the following cycle `empty` is 0 and `head_data` equals the pushed payload.
- R3: Tokens leave in the order they entered. While `empty` is 0, `head_data` shows the oldest held token.
- R4: The queue holds three tokens. Three pushes with no pop leave all three readable in order. A fourth push while three are held, without a pop in the same cycle, breaks the protocol.
- R5: When the queue is not empty, a push and a pop in the same cycle both take effect. The number of held tokens stays the same.
- R6: A `flush` empties the queue on the next cycle. It overrides a push or a pop in the same cycle.
- R7: A pop removes exactly one token. Popping the last token makes `empty` 1 on the next cycle. A pop while `empty` is 1 breaks the protocol.
- R8: In a cycle with no push, no pop and no flush, `empty` and `head_data` hold their values.
- R9: The read and write positions wrap modulo three. Order is therefore kept across any number of push and pop cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both pipelines |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Producer deposits a token this cycle (no ready) |
| push_data | input | TOK_W | Token payload |
| pop | input | 1 | Consumer takes the head token this cycle |
| flush | input | 1 | Synchronous clear of all held tokens |
| empty | output | 1 | No token held |
| head_data | output | TOK_W | Payload of the oldest token |

## Verification
The protocol checks take two things for granted about the inputs. The producer never pushes a fourth token unless a pop happens in the same cycle. The consumer never pops while `empty` is 1. The random stimulus keeps within both rules by consulting the bench's own model of the occupancy. It asserts `pop` only when the model holds a token. It asserts `push_valid` only when the model holds fewer than three tokens, or when a pop occurs in the same cycle. The directed corner cases follow the same two rules.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int unsigned TSQ_DEPTH = 3;
  localparam int unsigned TSQ_TOK_W = 4;

  function automatic int unsigned ptr_width(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/tsq_ptr.sv
module tsq_ptr #(
  parameter int unsigned DEPTH = tsq_pkg::TSQ_DEPTH,
  localparam int unsigned PW = tsq_pkg::ptr_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [PW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ptr_q <= '0;
    end else if (adv) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/tsq_store.sv
module tsq_store #(
  parameter int unsigned DEPTH = tsq_pkg::TSQ_DEPTH,
  parameter int unsigned TOK_W = tsq_pkg::TSQ_TOK_W,
  localparam int unsigned PW = tsq_pkg::ptr_width(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PW-1:0]    wr_ptr,
  input  logic [TOK_W-1:0] wr_data,
  input  logic [PW-1:0]    rd_ptr,
  output logic [TOK_W-1:0] rd_data
);
  logic [TOK_W-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (wr_ptr == PW'(i))) begin
        slot_q[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = slot_q[0];
    for (int j = 0; j < DEPTH; j++) begin
      if (rd_ptr == PW'(j)) rd_data = slot_q[j];
    end
  end
endmodule

// File: rtl/tsq_occ.sv
module tsq_occ #(
  parameter int unsigned DEPTH = tsq_pkg::TSQ_DEPTH,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count,
  output logic          is_empty
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign count    = cnt_q;
  assign is_empty = (cnt_q == '0);
endmodule

// File: rtl/tok_sync_queue.sv
module tok_sync_queue #(
  parameter int unsigned DEPTH = tsq_pkg::TSQ_DEPTH,
  parameter int unsigned TOK_W = tsq_pkg::TSQ_TOK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [TOK_W-1:0] push_data,
  input  logic             pop,
  input  logic             flush,
  output logic             empty,
  output logic [TOK_W-1:0] head_data
);
  localparam int unsigned PW = tsq_pkg::ptr_width(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          push_eff;
  logic          pop_eff;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [CW-1:0] occ_q;
  logic          occ_empty;

  // flush wins over both ends; a pop is only honoured on a held token
  assign push_eff = push_valid && !flush;
  assign pop_eff  = pop && !occ_empty && !flush;

  tsq_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
    .clk(clk), .rst_n(rst_n), .clr(flush), .adv(push_eff), .ptr(wr_ptr)
  );

  tsq_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
    .clk(clk), .rst_n(rst_n), .clr(flush), .adv(pop_eff), .ptr(rd_ptr)
  );

  tsq_store #(.DEPTH(DEPTH), .TOK_W(TOK_W)) u_store (
    .clk(clk), .we(push_eff), .wr_ptr(wr_ptr), .wr_data(push_data),
    .rd_ptr(rd_ptr), .rd_data(head_data)
  );

  tsq_occ #(.DEPTH(DEPTH)) u_occ (
    .clk(clk), .rst_n(rst_n), .clr(flush), .inc(push_eff), .dec(pop_eff),
    .count(occ_q), .is_empty(occ_empty)
  );

  assign empty = occ_empty;
endmodule

// File: rtl/tok_sync_queue_chk.sv
module tok_sync_queue_chk #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned TOK_W = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic             pop,
  input logic             flush,
  input logic             empty,
  input logic [TOK_W-1:0] head_data,
  input logic [CW-1:0]    occ
);
  // R4: protocol, no fourth token without a simultaneous pop
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !flush && !pop) |-> (occ != CW'(DEPTH)));

  // R7: protocol, consumer never pops an empty queue
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R6: flush leaves the queue empty on the next cycle
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

  // R2: an accepted push is visible on the next cycle
  a_r2_push_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !flush) |=> !empty);

  // R5: push and pop together keep the count
  a_r5_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && pop && !flush && !empty) |=> (occ == $past(occ)));

  // R8: idle cycles hold the outputs
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_valid && !pop && !flush) |=> ($stable(empty) && $stable(head_data)));
endmodule

bind tok_sync_queue tok_sync_queue_chk #(.DEPTH(DEPTH), .TOK_W(TOK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .pop(pop),
  .flush(flush), .empty(empty), .head_data(head_data), .occ(occ_q)
);

// File: tb/tb_tok_sync_queue.sv
module tb_tok_sync_queue;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         push_valid = 1'b0;
  logic [W-1:0] push_data = '0;
  logic         pop = 1'b0;
  logic         flush = 1'b0;
  logic         empty;
  logic [W-1:0] head_data;

  int vec_cnt = 0;
  int bad_cnt = 0;

  logic [W-1:0] mq [3];
  int mc = 0;

  always #4 clk = ~clk;

  tok_sync_queue #(.DEPTH(3), .TOK_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .pop(pop), .flush(flush), .empty(empty), .head_data(head_data)
  );

  function automatic logic exp_empty();
    return (mc == 0);
  endfunction

  task automatic check(input string tag);
    vec_cnt++;
    if (empty !== exp_empty()) begin
      bad_cnt++;
      $display("FAIL %s empty actual=%b expected=%b", tag, empty, exp_empty());
    end else if (mc != 0 && head_data !== mq[0]) begin
      bad_cnt++;
      $display("FAIL %s head actual=%h expected=%h", tag, head_data, mq[0]);
    end
  endtask

  task automatic model_update(input logic pu, input logic [W-1:0] d,
                              input logic po, input logic fl);
    if (fl) begin
      mc = 0;
    end else begin
      if (po && mc > 0) begin
        mq[0] = mq[1];
        mq[1] = mq[2];
        mc--;
      end
      if (pu && mc < 3) begin
        mq[mc] = d;
        mc++;
      end
    end
  endtask

  // called at a falling edge; applies inputs over one rising edge
  task automatic step(input logic pu, input logic [W-1:0] d,
                      input logic po, input logic fl, input string tag);
    push_valid = pu; push_data = d; pop = po; flush = fl;
    @(posedge clk);
    model_update(pu, d, po, fl);
    @(negedge clk);
    push_valid = 1'b0; pop = 1'b0; flush = 1'b0;
    check(tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // R2: no same-cycle bypass
    push_valid = 1'b1; push_data = 4'hA;
    check("R2");
    step(1'b1, 4'hA, 1'b0, 1'b0, "R2");

    // R4: fill to three, order kept
    step(1'b1, 4'h3, 1'b0, 1'b0, "R4");
    step(1'b1, 4'h7, 1'b0, 1'b0, "R4");
    // R5: push and pop at full
    step(1'b1, 4'hC, 1'b1, 1'b0, "R5");
    // R8: idle hold
    step(1'b0, 4'hF, 1'b0, 1'b0, "R8");
    step(1'b0, 4'h0, 1'b0, 1'b0, "R8");
    // R7 and R3: drain one at a time
    step(1'b0, 4'h0, 1'b1, 1'b0, "R3");
    step(1'b0, 4'h0, 1'b1, 1'b0, "R3");
    step(1'b0, 4'h0, 1'b1, 1'b0, "R7");
    // R6: flush overriding a push
    step(1'b1, 4'h5, 1'b0, 1'b0, "R6");
    step(1'b1, 4'h9, 1'b0, 1'b1, "R6");
    step(1'b0, 4'h0, 1'b0, 1'b0, "R6");

    // R9: random traffic across many wraps
    for (int i = 0; i < 3000; i++) begin
      logic fl, po, pu;
      logic [W-1:0] d;
      fl = (($urandom % 32) == 0);
      po = (mc > 0) && $urandom[0];
      pu = (mc < 3 || po) && $urandom[0];
      d  = W'($urandom);
      step(pu, d, po, fl, "R9");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad_cnt++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end
endmodule